// File: doc/BRIEF.md
# Phase-Counting Encoder Timer Pair

This block turns the two-wire outputs of incremental position encoders into signed position counts. It holds two 16-bit counters. Each one watches a pair of phase inputs, resynchronises them to the system clock and turns their transitions into count steps with a direction. A per-counter mode code chooses how transitions are read: full quadrature, pulse plus direction, or quadrature that counts on the second phase only.

A shared control register can join the two counters into one 32-bit counter. It also chooses whether the second counter (or the joined counter) listens to the first input pair (A/B) or the second pair (C/D). Each counter has a ceiling: stepping up from the ceiling clears the count, and stepping down from zero reloads the ceiling. Software reads and writes all state through a small single-cycle register port.

Top module: `encoder_pair_timer`

## Requirements
- R1: After a synchronous reset both mode registers read 0x04, both counts read 0, both 16-bit ceilings read 0xFFFF, the 32-bit ceiling reads 0xFFFFFFFF, the shared register reads 0 and the status registers read 0x80.
- R2: A phase change driven between two rising clock edges shows up in the count after the third rising edge that follows it. There are two synchroniser flops and one edge register before the count.
- R3: Mode code 4 (low 4 bits of the 8-bit mode register) is full quadrature, with one step per transition of either phase. With the pair written as {A,B}, the order 00→10→11→01→00 counts up and the reverse order counts down.
- R4: In quadrature decoding, a sample in which both phases of the pair changed together produces no step.
- R5: Mode code 5 is pulse plus direction. Each rising edge of the first phase of the pair moves the count by one: up while the second phase is 1, down while it is 0. Falling edges and changes of the second phase alone do not count.
- R6: Mode code 7 counts on both edges of the second phase only, with the direction taken from the R3 sequence. Edges of the first phase do not count.
- R7: Any other mode code, including the two reserved codes 6 and 9, holds the count. Bits 7:4 of the mode register are stored and read back, and they do not affect decoding.
- R8: Bit 7 of a counter's status register is the direction of its most recent step (1 up, 0 down). It changes only when that counter takes a step.
- R9: Stepping up from a count equal to the ceiling gives 0. Stepping down from 0 gives the ceiling value.
- R10: Shared bit 1 picks the pair for the second counter: A/B when 0, C/D when 1. The first counter always uses A/B while the counters are independent.
- R11: Shared bit 0 set joins the counters. The 32-bit count {upper = counter 1, lower = counter 0} steps as one value, so a carry out of the lower half raises the upper half and a borrow lowers it. It uses counter 0's mode, the pair chosen by shared bit 1, and its own 32-bit ceiling. Its direction shows in status register 0.
- R12: Register offsets on reg_addr: 0 mode 0, 1 mode 1, 2 count 0, 3 count 1, 4 ceiling 0, 5 ceiling 1, 6 status 0, 7 status 1, 8 shared, 9 32-bit count, 10 32-bit ceiling. Writes take effect at the next rising edge, and reads are combinational.
- R13: When a software write to a count falls in the same cycle as a decoded step, the written value is stored. The step is dropped, but the direction flag still records it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_a | input | 1 | First phase of pair A/B (asynchronous) |
| phase_b | input | 1 | Second phase of pair A/B (asynchronous) |
| phase_c | input | 1 | First phase of pair C/D (asynchronous) |
| phase_d | input | 1 | Second phase of pair C/D (asynchronous) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset (see R12) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |

## Verification
The collision that matters is a software count write that lands in the same clock cycle as a decoded encoder step. The bench changes a phase pair, counts the synchroniser latency forward, and raises the count write exactly on the edge where the step is taken. It then expects the written value in the count, with the status flag showing the dropped step's direction. Right after, a plain step is timed cycle by cycle to show the count is still one edge short two cycles after the change and updated on the third.

// File: rtl/enc_pkg.sv
package enc_pkg;

    // Register offsets
    localparam int unsigned ADDR_W     = 4;
    localparam int unsigned MODE_W     = 8;
    localparam logic [ADDR_W-1:0] ADR_MODE0  = 4'h0;
    localparam logic [ADDR_W-1:0] ADR_MODE1  = 4'h1;
    localparam logic [ADDR_W-1:0] ADR_CNT0   = 4'h2;
    localparam logic [ADDR_W-1:0] ADR_CNT1   = 4'h3;
    localparam logic [ADDR_W-1:0] ADR_CEIL0  = 4'h4;
    localparam logic [ADDR_W-1:0] ADR_CEIL1  = 4'h5;
    localparam logic [ADDR_W-1:0] ADR_STAT0  = 4'h6;
    localparam logic [ADDR_W-1:0] ADR_STAT1  = 4'h7;
    localparam logic [ADDR_W-1:0] ADR_SHARED = 4'h8;
    localparam logic [ADDR_W-1:0] ADR_LCNT   = 4'h9;
    localparam logic [ADDR_W-1:0] ADR_LCEIL  = 4'hA;

    // Shared control bit positions
    localparam int unsigned SH_JOIN_BIT = 0;
    localparam int unsigned SH_PAIR_BIT = 1;

    // Decode mode codes (low nibble of a mode register)
    typedef enum logic [3:0] {
        MODE_QUAD      = 4'd4,
        MODE_PULSE_DIR = 4'd5,
        MODE_RSVD_LO   = 4'd6,
        MODE_B_ONLY    = 4'd7,
        MODE_RSVD_HI   = 4'd9
    } dec_mode_e;

    localparam logic [MODE_W-1:0] MODE_RESET = 8'h04;

    // One phase pair: first and second phase
    typedef struct packed {
        logic first;
        logic second;
    } pair_t;

    // Decoder result
    typedef struct packed {
        logic step;
        logic up;
    } stepdir_t;

    // Quadrature direction: up when the first phase now differs from
    // the previous second phase.
    function automatic logic quad_up(input pair_t cur, input pair_t prev);
        return cur.first ^ prev.second;
    endfunction

    function automatic logic [MODE_W-1:0] status_byte(input logic dir_up);
        return {dir_up, 7'b0};
    endfunction

endpackage

// File: rtl/enc_sync.sv
module enc_sync #(
    parameter int unsigned N      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] cur,
    output logic [N-1:0] prev
);

    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
        logic [N-1:0] q;
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= din;
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= g_stage[g-1].q;
            end
        end
    end

    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= g_stage[STAGES-1].q;
    end

    assign cur  = g_stage[STAGES-1].q;
    assign prev = prev_q;

endmodule

// File: rtl/enc_phase_decode.sv
module enc_phase_decode
    import enc_pkg::*;
(
    input  logic [3:0] mode,
    input  pair_t      cur,
    input  pair_t      prev,
    output stepdir_t   sd
);

    logic moved_first;
    logic moved_second;

    always_comb begin
        moved_first  = cur.first  ^ prev.first;
        moved_second = cur.second ^ prev.second;
        sd           = '0;
        case (mode)
            MODE_QUAD: begin
                sd.step = moved_first ^ moved_second;
                sd.up   = quad_up(cur, prev);
            end
            MODE_PULSE_DIR: begin
                sd.step = cur.first & ~prev.first;
                sd.up   = cur.second;
            end
            MODE_B_ONLY: begin
                sd.step = moved_second & ~moved_first;
                sd.up   = quad_up(cur, prev);
            end
            default: sd = '0;
        endcase
    end

endmodule

// File: rtl/enc_next_count.sv
module enc_next_count #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] ceil,
    input  logic         step,
    input  logic         up,
    output logic [W-1:0] nxt
);

    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        if (!step)            nxt = cnt;
        else if (up)          nxt = (cnt == ceil) ? '0 : cnt + ONE;
        else                  nxt = (cnt == '0) ? ceil : cnt - ONE;
    end

endmodule

// File: rtl/encoder_pair_timer.sv
module encoder_pair_timer
    import enc_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                phase_a,
    input  logic                phase_b,
    input  logic                phase_c,
    input  logic                phase_d,
    input  logic                reg_wr_en,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [2*CNT_W-1:0]  reg_wdata,
    output logic [2*CNT_W-1:0]  reg_rdata
);

    localparam int unsigned LONG_W = 2 * CNT_W;
    localparam int unsigned N_DEC  = 2;

    // Synchronised phases: bit0 A, bit1 B, bit2 C, bit3 D
    logic [3:0] cur_bits;
    logic [3:0] prev_bits;

    enc_sync #(.N(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({phase_d, phase_c, phase_b, phase_a}),
        .cur  (cur_bits),
        .prev (prev_bits)
    );

    // Architectural state
    logic [MODE_W-1:0] mode0_q, mode1_q;
    logic [CNT_W-1:0]  cnt0_q, cnt1_q;
    logic [CNT_W-1:0]  ceil0_q, ceil1_q;
    logic [LONG_W-1:0] lceil_q;
    logic [1:0]        shared_q;
    logic              dir0_q, dir1_q;

    logic joined;
    logic pair_cd;
    assign joined  = shared_q[SH_JOIN_BIT];
    assign pair_cd = shared_q[SH_PAIR_BIT];

    // Pair routing
    pair_t ab_cur, ab_prev, cd_cur, cd_prev, sel_cur, sel_prev;
    assign ab_cur   = '{first: cur_bits[0],  second: cur_bits[1]};
    assign ab_prev  = '{first: prev_bits[0], second: prev_bits[1]};
    assign cd_cur   = '{first: cur_bits[2],  second: cur_bits[3]};
    assign cd_prev  = '{first: prev_bits[2], second: prev_bits[3]};
    assign sel_cur  = pair_cd ? cd_cur  : ab_cur;
    assign sel_prev = pair_cd ? cd_prev : ab_prev;

    pair_t      dec_cur  [N_DEC];
    pair_t      dec_prev [N_DEC];
    logic [3:0] dec_mode [N_DEC];
    stepdir_t   dec_sd   [N_DEC];

    // Decoder 0 serves the first counter or the joined counter
    assign dec_cur[0]  = joined ? sel_cur  : ab_cur;
    assign dec_prev[0] = joined ? sel_prev : ab_prev;
    assign dec_mode[0] = mode0_q[3:0];
    assign dec_cur[1]  = sel_cur;
    assign dec_prev[1] = sel_prev;
    assign dec_mode[1] = mode1_q[3:0];

    genvar gd;
    for (gd = 0; gd < N_DEC; gd++) begin : g_dec
        enc_phase_decode u_dec (
            .mode (dec_mode[gd]),
            .cur  (dec_cur[gd]),
            .prev (dec_prev[gd]),
            .sd   (dec_sd[gd])
        );
    end

    // Next-count paths: two halves and the joined value
    logic [CNT_W-1:0]  nxt0, nxt1;
    logic [LONG_W-1:0] nxt_long;

    enc_next_count #(.W(CNT_W)) u_next0 (
        .cnt  (cnt0_q),
        .ceil (ceil0_q),
        .step (dec_sd[0].step),
        .up   (dec_sd[0].up),
        .nxt  (nxt0)
    );

    enc_next_count #(.W(CNT_W)) u_next1 (
        .cnt  (cnt1_q),
        .ceil (ceil1_q),
        .step (dec_sd[1].step),
        .up   (dec_sd[1].up),
        .nxt  (nxt1)
    );

    enc_next_count #(.W(LONG_W)) u_next_long (
        .cnt  ({cnt1_q, cnt0_q}),
        .ceil (lceil_q),
        .step (dec_sd[0].step),
        .up   (dec_sd[0].up),
        .nxt  (nxt_long)
    );

    // Write decode
    logic wr_mode0, wr_mode1, wr_cnt0, wr_cnt1, wr_ceil0, wr_ceil1;
    logic wr_shared, wr_lcnt, wr_lceil;

    always_comb begin
        wr_mode0  = reg_wr_en && (reg_addr == ADR_MODE0);
        wr_mode1  = reg_wr_en && (reg_addr == ADR_MODE1);
        wr_cnt0   = reg_wr_en && (reg_addr == ADR_CNT0);
        wr_cnt1   = reg_wr_en && (reg_addr == ADR_CNT1);
        wr_ceil0  = reg_wr_en && (reg_addr == ADR_CEIL0);
        wr_ceil1  = reg_wr_en && (reg_addr == ADR_CEIL1);
        wr_shared = reg_wr_en && (reg_addr == ADR_SHARED);
        wr_lcnt   = reg_wr_en && (reg_addr == ADR_LCNT);
        wr_lceil  = reg_wr_en && (reg_addr == ADR_LCEIL);
    end

    // Configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            mode0_q  <= MODE_RESET;
            mode1_q  <= MODE_RESET;
            ceil0_q  <= '1;
            ceil1_q  <= '1;
            lceil_q  <= '1;
            shared_q <= '0;
        end else begin
            if (wr_mode0)  mode0_q  <= reg_wdata[MODE_W-1:0];
            if (wr_mode1)  mode1_q  <= reg_wdata[MODE_W-1:0];
            if (wr_ceil0)  ceil0_q  <= reg_wdata[CNT_W-1:0];
            if (wr_ceil1)  ceil1_q  <= reg_wdata[CNT_W-1:0];
            if (wr_lceil)  lceil_q  <= reg_wdata;
            if (wr_shared) shared_q <= reg_wdata[1:0];
        end
    end

    // Counts: decoded step first, software write overrides it
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt0_q <= '0;
            cnt1_q <= '0;
        end else begin
            if (joined) begin
                cnt0_q <= nxt_long[CNT_W-1:0];
                cnt1_q <= nxt_long[LONG_W-1:CNT_W];
            end else begin
                cnt0_q <= nxt0;
                cnt1_q <= nxt1;
            end
            if (wr_cnt0) cnt0_q <= reg_wdata[CNT_W-1:0];
            if (wr_cnt1) cnt1_q <= reg_wdata[CNT_W-1:0];
            if (wr_lcnt) begin
                cnt0_q <= reg_wdata[CNT_W-1:0];
                cnt1_q <= reg_wdata[LONG_W-1:CNT_W];
            end
        end
    end

    // Direction flags follow every step, written or not
    always_ff @(posedge clk) begin
        if (rst) begin
            dir0_q <= 1'b1;
            dir1_q <= 1'b1;
        end else begin
            if (dec_sd[0].step)            dir0_q <= dec_sd[0].up;
            if (!joined && dec_sd[1].step) dir1_q <= dec_sd[1].up;
        end
    end

    // Read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADR_MODE0:  reg_rdata = LONG_W'(mode0_q);
            ADR_MODE1:  reg_rdata = LONG_W'(mode1_q);
            ADR_CNT0:   reg_rdata = LONG_W'(cnt0_q);
            ADR_CNT1:   reg_rdata = LONG_W'(cnt1_q);
            ADR_CEIL0:  reg_rdata = LONG_W'(ceil0_q);
            ADR_CEIL1:  reg_rdata = LONG_W'(ceil1_q);
            ADR_STAT0:  reg_rdata = LONG_W'(status_byte(dir0_q));
            ADR_STAT1:  reg_rdata = LONG_W'(status_byte(dir1_q));
            ADR_SHARED: reg_rdata = LONG_W'(shared_q);
            ADR_LCNT:   reg_rdata = {cnt1_q, cnt0_q};
            ADR_LCEIL:  reg_rdata = lceil_q;
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/encoder_pair_timer_chk.sv
module encoder_pair_timer_chk
    import enc_pkg::*;
#(
    parameter int unsigned CW = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [2*CW-1:0]   reg_wdata,
    input logic [1:0]        shared,
    input logic [MODE_W-1:0] mode0,
    input logic [CW-1:0]     cnt0,
    input logic [CW-1:0]     ceil0,
    input logic              dir0,
    input logic              step0,
    input logic [3:0]        cur_bits,
    input logic [3:0]        prev_bits
);

    logic both_moved;
    logic known_code;
    assign both_moved = (cur_bits[0] ^ prev_bits[0]) && (cur_bits[1] ^ prev_bits[1]);
    assign known_code = (mode0[3:0] == 4'd4) || (mode0[3:0] == 4'd5) || (mode0[3:0] == 4'd7);

    // R4: simultaneous jump of both A/B phases leaves the first counter alone
    a_r4_jump_ignored: assert property (@(posedge clk) disable iff (rst)
        (both_moved && mode0[3:0] == 4'd4 && !shared[0] && !reg_wr_en) |=> $stable(cnt0));

    // R7: unsupported code holds the count
    a_r7_hold_unknown: assert property (@(posedge clk) disable iff (rst)
        (!known_code && !shared[0] && !reg_wr_en) |=> $stable(cnt0));

    // R8: direction flag moves only with a step
    a_r8_dir_on_step: assert property (@(posedge clk) disable iff (rst)
        (!step0) |=> $stable(dir0));

    // R9: a count at or below its ceiling stays there
    a_r9_within_ceiling: assert property (@(posedge clk) disable iff (rst)
        (!shared[0] && !reg_wr_en && cnt0 <= ceil0) |=> (cnt0 <= ceil0));

    // R13: a count write always lands, step or no step
    a_r13_write_wins: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_addr == ADR_CNT0) |=> (cnt0 == $past(reg_wdata[CW-1:0])));

endmodule

bind encoder_pair_timer encoder_pair_timer_chk #(.CW(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .shared    (shared_q),
    .mode0     (mode0_q),
    .cnt0      (cnt0_q),
    .ceil0     (ceil0_q),
    .dir0      (dir0_q),
    .step0     (dec_sd[0].step),
    .cur_bits  (cur_bits),
    .prev_bits (prev_bits)
);

// File: tb/tb_encoder_pair_timer.sv
`timescale 1ns/1ps
module tb_encoder_pair_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        phase_a = 1'b0, phase_b = 1'b0, phase_c = 1'b0, phase_d = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    always #2.5 clk = ~clk;   // 200 MHz

    encoder_pair_timer dut (
        .clk(clk), .rst(rst),
        .phase_a(phase_a), .phase_b(phase_b), .phase_c(phase_c), .phase_d(phase_d),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    typedef struct {
        logic [3:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    int n_total = 0;
    int n_pass  = 0;
    bit done    = 0;

    // Monitor: pops expected items and compares against the read port
    initial begin
        forever begin
            item_t it;
            wait (sb_q.size() != 0);
            it = sb_q[0];
            reg_addr = it.addr;
            #1;
            n_total++;
            if (reg_rdata === it.exp) n_pass++;
            else $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.addr, reg_rdata, it.exp);
            void'(sb_q.pop_front());
        end
    end

    // Driver side
    task automatic expect_reg(input logic [3:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.addr = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    // {first,second}: up order 00 -> 10 -> 11 -> 01 -> 00
    function automatic logic [1:0] gray_next(input logic [1:0] s, input bit up);
        logic [1:0] n;
        if (up) begin
            case (s)
                2'b00: n = 2'b10;
                2'b10: n = 2'b11;
                2'b11: n = 2'b01;
                default: n = 2'b00;
            endcase
        end else begin
            case (s)
                2'b00: n = 2'b01;
                2'b01: n = 2'b11;
                2'b11: n = 2'b10;
                default: n = 2'b00;
            endcase
        end
        return n;
    endfunction

    task automatic ab_steps(input bit up, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            {phase_a, phase_b} = gray_next({phase_a, phase_b}, up);
            settle();
        end
    endtask

    task automatic cd_steps(input bit up, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            {phase_c, phase_d} = gray_next({phase_c, phase_d}, up);
            settle();
        end
    endtask

    task automatic set_a(input logic v);
        @(negedge clk); phase_a = v; settle();
    endtask

    task automatic set_b(input logic v);
        @(negedge clk); phase_b = v; settle();
    endtask

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_total++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_pass, n_total);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        expect_reg(4'h0, 32'h04, "R1 mode0");
        expect_reg(4'h1, 32'h04, "R1 mode1");
        expect_reg(4'h2, 32'h0, "R1 count0");
        expect_reg(4'h3, 32'h0, "R1 count1");
        expect_reg(4'h4, 32'hFFFF, "R1 ceil0");
        expect_reg(4'h5, 32'hFFFF, "R1 ceil1");
        expect_reg(4'hA, 32'hFFFF_FFFF, "R1 long ceil");
        expect_reg(4'h8, 32'h0, "R1 shared");
        expect_reg(4'h6, 32'h80, "R1 status0");

        // R3 quadrature up / down
        ab_steps(1'b1, 4);
        expect_reg(4'h2, 32'd4, "R3 quad up");
        expect_reg(4'h3, 32'd4, "R10 counter1 on A/B by default");
        expect_reg(4'h6, 32'h80, "R8 dir up");
        ab_steps(1'b0, 2);                       // AB now 11
        expect_reg(4'h2, 32'd2, "R3 quad down");
        expect_reg(4'h6, 32'h00, "R8 dir down");

        // R4 illegal jump 11 -> 00
        @(negedge clk); phase_a = 1'b0; phase_b = 1'b0; settle();
        expect_reg(4'h2, 32'd2, "R4 double jump ignored");
        expect_reg(4'h6, 32'h00, "R8 flag held without step");

        // R5 pulse plus direction
        reg_write(4'h0, 32'h05);
        expect_reg(4'h0, 32'h05, "R12 mode0 readback");
        set_b(1'b1);
        expect_reg(4'h2, 32'd2, "R5 second phase alone no count");
        for (int i = 0; i < 3; i++) begin set_a(1'b1); set_a(1'b0); end
        expect_reg(4'h2, 32'd5, "R5 rising edges count up");
        expect_reg(4'h6, 32'h80, "R5 dir up");
        set_b(1'b0);
        set_a(1'b1); set_a(1'b0);
        expect_reg(4'h2, 32'd4, "R5 count down when second low");
        expect_reg(4'h6, 32'h00, "R5 dir down");

        // R6 second-phase-only quadrature
        reg_write(4'h0, 32'h07);
        set_a(1'b1); set_a(1'b0);
        expect_reg(4'h2, 32'd4, "R6 first phase ignored");
        set_b(1'b1);
        expect_reg(4'h2, 32'd3, "R6 B rise from 00 counts down");
        expect_reg(4'h6, 32'h00, "R6 dir down");
        set_b(1'b0);
        expect_reg(4'h2, 32'd4, "R6 B fall counts up");

        // R7 reserved code holds; upper nibble ignored
        reg_write(4'h0, 32'h06);
        ab_steps(1'b1, 2);                       // AB 11
        expect_reg(4'h2, 32'd4, "R7 reserved code holds");
        reg_write(4'h0, 32'h14);
        expect_reg(4'h0, 32'h14, "R7 upper nibble stored");
        ab_steps(1'b1, 2);                       // AB 00
        expect_reg(4'h2, 32'd6, "R7 upper nibble ignored");
        reg_write(4'h0, 32'h04);

        // R9 ceiling clear and reload
        reg_write(4'h4, 32'd5);
        reg_write(4'h2, 32'd3);
        ab_steps(1'b1, 2);
        expect_reg(4'h2, 32'd5, "R9 reach ceiling");
        ab_steps(1'b1, 1);                       // AB 01
        expect_reg(4'h2, 32'd0, "R9 clear past ceiling");
        ab_steps(1'b0, 1);                       // AB 11
        expect_reg(4'h2, 32'd5, "R9 down from zero reloads ceiling");
        reg_write(4'h4, 32'hFFFF);

        // R10 pair select
        reg_write(4'h8, 32'h2);
        reg_write(4'h3, 32'h100);
        reg_write(4'h2, 32'h10);
        ab_steps(1'b1, 2);                       // AB 00
        expect_reg(4'h2, 32'h12, "R10 counter0 stays on A/B");
        expect_reg(4'h3, 32'h100, "R10 counter1 ignores A/B");
        cd_steps(1'b1, 3);                       // CD 01
        expect_reg(4'h3, 32'h103, "R10 counter1 follows C/D");
        expect_reg(4'h2, 32'h12, "R10 counter0 ignores C/D");
        cd_steps(1'b1, 1);                       // CD 00

        // R11 joined counter
        reg_write(4'h8, 32'h1);
        reg_write(4'h9, 32'h0000_FFFF);
        ab_steps(1'b1, 1);                       // AB 10
        expect_reg(4'h9, 32'h0001_0000, "R11 carry into upper half");
        expect_reg(4'h3, 32'h0001, "R11 upper half on count1");
        ab_steps(1'b0, 1);                       // AB 00
        expect_reg(4'h9, 32'h0000_FFFF, "R11 borrow from upper half");
        reg_write(4'h9, 32'h0);
        ab_steps(1'b0, 1);                       // AB 01
        expect_reg(4'h9, 32'hFFFF_FFFF, "R9 joined down from zero");
        reg_write(4'hA, 32'h0001_0003);
        reg_write(4'h9, 32'h0001_0002);
        ab_steps(1'b1, 2);                       // AB 10
        expect_reg(4'h9, 32'h0, "R11 long ceiling clear");
        expect_reg(4'h6, 32'h80, "R11 dir in status0");
        reg_write(4'h8, 32'h3);
        cd_steps(1'b1, 1);                       // CD 10
        expect_reg(4'h9, 32'h1, "R11 joined on C/D");

        // R13 write and step in the same cycle, then R2 latency
        reg_write(4'h8, 32'h0);
        reg_write(4'h2, 32'h50);
        @(negedge clk); phase_a = 1'b0;          // AB 10 -> 00: down step
        @(negedge clk);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 4'h2; reg_wdata = 32'h77;
        @(negedge clk);
        reg_wr_en = 1'b0;
        settle();
        expect_reg(4'h2, 32'h77, "R13 write wins over step");
        expect_reg(4'h6, 32'h00, "R13 flag records dropped step");
        @(negedge clk); phase_a = 1'b1;          // AB 00 -> 10: up step
        @(negedge clk);
        @(negedge clk);
        expect_reg(4'h2, 32'h77, "R2 not yet after two edges");
        @(negedge clk);
        expect_reg(4'h2, 32'h78, "R2 updated after third edge");

        done = 1;
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end

endmodule